// File: doc/BRIEF.md
# Striped Block Request Splitter

This block turns one host block request into a stream of per-target hardware commands for a storage array whose address space is striped across a power-of-two number of targets. A request names a starting sector (512-byte units), a length in bytes and a kind: read, write or discard. The splitter cuts it into chunks that never cross a 4096-byte hardware block boundary. For each chunk it works out which target owns the bytes and the block address inside that target. It also packs the position and size of the chunk within its block into a sub-page byte.

Commands leave on a valid/ready stream with an opcode, a target index, a local block address and the sub-page byte. The stripe size in bytes and the base-2 log of the target count are configuration inputs. The configuration is checked and registered inside the block. A one-cycle done pulse marks the end of each request.

Top module: `stripe_splitter`

## Requirements
- R1: The byte address of a request is its start sector shifted left by 9; the first command of a request is computed from that address.
- R2: The target of a chunk at byte address A is (A >> log2(stripe bytes)) & (2^cfg_tgt_log − 1).
- R3: The local block of a chunk at byte address A is (((A >> cfg_tgt_log) & ~(stripe − 1)) | (A & (stripe − 1))) >> 12.
- R4: For reads and writes, a chunk starts at offset A mod 4096, has length min(remaining bytes, 4096 − offset), and the next chunk starts at A plus that length.
- R5: The sub-page byte holds offset/512 in bits [2:0] and length/512 in bits [6:4]; bits 3 and 7 are zero; a full 4096-byte chunk carries count 0.
- R6: A discard is issued as ceil(length/4096) steps that each advance the address by 4096, and every discard command has a sub-page byte of 0.
- R7: req_kind 2'b00 gives opcode 0xC0 (read), 2'b01 gives 0x80 (write), and 2'b1x gives 0x70 (discard).
- R8: While cmd_valid is high and cmd_ready is low, every command field holds its value, and no chunk is dropped or repeated.
- R9: done is high for exactly the one cycle after the last command of a request is accepted, or the one cycle after a zero-length request is accepted, and that request issues no commands.
- R10: A stripe size that is zero or not a power of two raises cfg_err, one cycle after the input changes, and holds req_ready low, so a request offered then is ignored.
- R11: req_ready is low from the acceptance of a request until its done pulse.
- R12: During reset cfg_err is high and req_ready, cmd_valid and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_stripe_bytes | input | ADDR_W | Stripe size in bytes, power of two |
| cfg_tgt_log | input | TL_W | log2 of the number of targets |
| cfg_err | output | 1 | Configuration rejected |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_sector | input | ADDR_W-9 | Start sector |
| req_bytes | input | LEN_W | Request length in bytes |
| req_kind | input | 2 | 00 read, 01 write, 1x discard |
| cmd_valid | output | 1 | Command valid |
| cmd_ready | input | 1 | Command accepted by consumer |
| cmd_opcode | output | 8 | Command opcode |
| cmd_target | output | TGT_W | Target index |
| cmd_lblock | output | ADDR_W-12 | Target-local block address |
| cmd_subpage | output | 8 | Packed sub-page offset and count |
| done | output | 1 | One-cycle end-of-request pulse |

## Verification
The assertions assume that the configuration inputs stay put while a request is in flight, and that request lengths are whole multiples of 512 bytes. If either is broken, the output fields have no defined meaning. The stimulus changes the stripe size and target count only between requests, with two idle cycles after each change, and builds every length from a count of sectors. The sweep covers unaligned starts, zero length, exact blocks and lengths one sector over a block. It also throttles cmd_ready with a pseudo-random pattern, so the output stream stalls while a command is held.

// File: rtl/split_pkg.sv
package split_pkg;
  localparam int SEC_LOG = 9;
  localparam int BLK_LOG = 12;

  localparam logic [7:0] OP_READ    = 8'hC0;
  localparam logic [7:0] OP_WRITE   = 8'h80;
  localparam logic [7:0] OP_DISCARD = 8'h70;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_LAST = 2'd2
  } split_state_e;
endpackage

// File: rtl/split_cfg_check.sv
module split_cfg_check #(
  parameter int ADDR_W = 32,
  parameter int TL_W = 2,
  parameter int TLOG_MAX = 3,
  parameter int SL_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] stripe_i,
  input  logic [TL_W-1:0]   tlog_i,
  output logic              err_o,
  output logic [SL_W-1:0]   slog_o,
  output logic [ADDR_W-1:0] smask_o,
  output logic [TL_W-1:0]   tlog_o
);
  logic            pow2;
  logic [SL_W-1:0] enc;

  always_comb begin
    pow2 = (stripe_i != '0) && ((stripe_i & (stripe_i - 1'b1)) == '0);
    enc = '0;
    for (int i = 0; i < ADDR_W; i++) begin
      if (stripe_i[i]) enc = SL_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_o   <= 1'b1;
      slog_o  <= '0;
      smask_o <= '0;
      tlog_o  <= '0;
    end else begin
      err_o   <= !pow2 || (int'(tlog_i) > TLOG_MAX);
      slog_o  <= enc;
      smask_o <= stripe_i - 1'b1;
      tlog_o  <= tlog_i;
    end
  end

  // R10: an accepted configuration is a single set bit at the encoded position
  a_r10_log_matches: assert property (@(posedge clk) disable iff (rst)
    !err_o |-> ($past(stripe_i) == (ADDR_W'(1) << slog_o)));
endmodule

// File: rtl/split_chunk_calc.sv
module split_chunk_calc
  import split_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W = 20,
  parameter int TGT_W = 3,
  parameter int TL_W = 2,
  parameter int SL_W = 5,
  parameter int LBA_W = ADDR_W - BLK_LOG
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  remain_i,
  input  logic              discard_i,
  input  logic [SL_W-1:0]   slog_i,
  input  logic [ADDR_W-1:0] smask_i,
  input  logic [TL_W-1:0]   tlog_i,
  output logic [TGT_W-1:0]  target_o,
  output logic [LBA_W-1:0]  lblock_o,
  output logic [7:0]        subpage_o,
  output logic [BLK_LOG:0]  clen_o
);
  localparam logic [BLK_LOG:0] BLK_BYTES = (BLK_LOG+1)'(1) << BLK_LOG;

  logic [BLK_LOG:0]  off;
  logic [BLK_LOG:0]  room;
  logic [TGT_W:0]    tmask_full;
  logic [ADDR_W-1:0] tsel;
  logic [ADDR_W-1:0] folded;

  always_comb begin
    off  = discard_i ? '0 : {1'b0, addr_i[BLK_LOG-1:0]};
    room = BLK_BYTES - off;
    if (remain_i < LEN_W'(room)) clen_o = remain_i[BLK_LOG:0];
    else                         clen_o = room;

    tmask_full = ((TGT_W+1)'(1) << tlog_i) - 1'b1;
    tsel       = addr_i >> slog_i;
    target_o   = tsel[TGT_W-1:0] & tmask_full[TGT_W-1:0];

    folded   = ((addr_i >> tlog_i) & ~smask_i) | (addr_i & smask_i);
    lblock_o = folded[ADDR_W-1:BLK_LOG];

    if (discard_i) subpage_o = 8'h00;
    else subpage_o = {1'b0, clen_o[BLK_LOG-1:SEC_LOG], 1'b0, off[BLK_LOG-1:SEC_LOG]};
  end
endmodule

// File: rtl/stripe_splitter.sv
module stripe_splitter
  import split_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W = 20,
  parameter int TLOG_MAX = 3,
  localparam int TL_W = $clog2(TLOG_MAX + 1),
  localparam int TGT_W = (TLOG_MAX > 0) ? TLOG_MAX : 1,
  localparam int SL_W = $clog2(ADDR_W),
  localparam int SECT_W = ADDR_W - SEC_LOG,
  localparam int LBA_W = ADDR_W - BLK_LOG
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cfg_stripe_bytes,
  input  logic [TL_W-1:0]   cfg_tgt_log,
  output logic              cfg_err,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [SECT_W-1:0] req_sector,
  input  logic [LEN_W-1:0]  req_bytes,
  input  logic [1:0]        req_kind,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [7:0]        cmd_opcode,
  output logic [TGT_W-1:0]  cmd_target,
  output logic [LBA_W-1:0]  cmd_lblock,
  output logic [7:0]        cmd_subpage,
  output logic              done
);
  logic              err_w;
  logic [SL_W-1:0]   slog_w;
  logic [ADDR_W-1:0] smask_w;
  logic [TL_W-1:0]   tlog_w;

  split_cfg_check #(
    .ADDR_W(ADDR_W), .TL_W(TL_W), .TLOG_MAX(TLOG_MAX), .SL_W(SL_W)
  ) u_cfg (
    .clk(clk), .rst(rst),
    .stripe_i(cfg_stripe_bytes), .tlog_i(cfg_tgt_log),
    .err_o(err_w), .slog_o(slog_w), .smask_o(smask_w), .tlog_o(tlog_w)
  );

  split_state_e      st_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  rem_q;
  logic              disc_q;
  logic [7:0]        op_q;

  logic [TGT_W-1:0]  c_target;
  logic [LBA_W-1:0]  c_lblock;
  logic [7:0]        c_subpage;
  logic [BLK_LOG:0]  c_len;

  split_chunk_calc #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .TGT_W(TGT_W), .TL_W(TL_W),
    .SL_W(SL_W), .LBA_W(LBA_W)
  ) u_calc (
    .addr_i(addr_q), .remain_i(rem_q), .discard_i(disc_q),
    .slog_i(slog_w), .smask_i(smask_w), .tlog_i(tlog_w),
    .target_o(c_target), .lblock_o(c_lblock), .subpage_o(c_subpage), .clen_o(c_len)
  );

  logic load_ok;
  logic last_chunk;

  assign cfg_err    = err_w;
  assign req_ready  = (st_q == ST_IDLE) && !err_w;
  assign load_ok    = !cmd_valid || cmd_ready;
  assign last_chunk = (rem_q <= LEN_W'(c_len));

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_IDLE;
      addr_q      <= '0;
      rem_q       <= '0;
      disc_q      <= 1'b0;
      op_q        <= OP_READ;
      cmd_valid   <= 1'b0;
      cmd_opcode  <= '0;
      cmd_target  <= '0;
      cmd_lblock  <= '0;
      cmd_subpage <= '0;
      done        <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (req_valid && req_ready) begin
            addr_q <= {req_sector, {SEC_LOG{1'b0}}};
            rem_q  <= req_bytes;
            disc_q <= req_kind[1];
            op_q   <= req_kind[1] ? OP_DISCARD : (req_kind[0] ? OP_WRITE : OP_READ);
            if (req_bytes == '0) done <= 1'b1;
            else                 st_q <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (load_ok) begin
            cmd_valid   <= 1'b1;
            cmd_opcode  <= op_q;
            cmd_target  <= c_target;
            cmd_lblock  <= c_lblock;
            cmd_subpage <= c_subpage;
            addr_q      <= addr_q + ADDR_W'(c_len);
            rem_q       <= last_chunk ? '0 : rem_q - LEN_W'(c_len);
            if (last_chunk) st_q <= ST_LAST;
          end
        end
        ST_LAST: begin
          if (cmd_ready) begin
            cmd_valid <= 1'b0;
            done      <= 1'b1;
            st_q      <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R8: a stalled command keeps every field
  a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_opcode) &&
      $stable(cmd_target) && $stable(cmd_lblock) && $stable(cmd_subpage)));

  // R9: done follows a final handshake or an empty request
  a_r9_done_cause: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(cmd_valid && cmd_ready) ||
              $past(req_valid && req_ready && (req_bytes == '0))));

  // R5: the two spare bits of the sub-page byte stay clear
  a_r5_spare_bits: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> (!cmd_subpage[3] && !cmd_subpage[7]));

  // R6: discard commands carry an empty sub-page byte
  a_r6_discard_subpage: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && (cmd_opcode == OP_DISCARD)) |-> (cmd_subpage == 8'h00));

  // R10: a rejected configuration blocks intake
  a_r10_err_blocks: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> !req_ready);

  // R11: no new request while a command is outstanding
  a_r11_busy_intake: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> !req_ready);
endmodule

// File: tb/stripe_splitter_tb.sv
module stripe_splitter_tb;
  localparam int ADDR_W = 32;
  localparam int LEN_W = 20;
  localparam int TL_W = 2;
  localparam int TGT_W = 3;
  localparam int LBA_W = ADDR_W - 12;
  localparam int SECT_W = ADDR_W - 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [ADDR_W-1:0] cfg_stripe_bytes = 32'd4096;
  logic [TL_W-1:0]   cfg_tgt_log = '0;
  logic              cfg_err;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [SECT_W-1:0] req_sector = '0;
  logic [LEN_W-1:0]  req_bytes = '0;
  logic [1:0]        req_kind = '0;
  logic              cmd_valid;
  logic              cmd_ready = 1'b0;
  logic [7:0]        cmd_opcode;
  logic [TGT_W-1:0]  cmd_target;
  logic [LBA_W-1:0]  cmd_lblock;
  logic [7:0]        cmd_subpage;
  logic              done;

  stripe_splitter #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .TLOG_MAX(3)) u_dut (
    .clk(clk), .rst(rst),
    .cfg_stripe_bytes(cfg_stripe_bytes), .cfg_tgt_log(cfg_tgt_log), .cfg_err(cfg_err),
    .req_valid(req_valid), .req_ready(req_ready), .req_sector(req_sector),
    .req_bytes(req_bytes), .req_kind(req_kind),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_opcode(cmd_opcode),
    .cmd_target(cmd_target), .cmd_lblock(cmd_lblock), .cmd_subpage(cmd_subpage),
    .done(done)
  );

  always #4 clk = ~clk;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  logic [7:0] lf = 8'hA5;

  task automatic chk(input longint act, input longint exp, input string tag);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic set_cfg(input int stripe, input int tl);
    @(negedge clk);
    cfg_stripe_bytes = ADDR_W'(stripe);
    cfg_tgt_log = TL_W'(tl);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run_req(input int sector, input int bytes, input int kind,
                         input int stripe, input int tl);
    longint a;
    int rem;
    int slog;
    int iter;
    int len;
    int off;
    bit first;
    bit stall;
    bit rdy;
    logic [7:0] h_op;
    logic [7:0] h_sub;
    logic [TGT_W-1:0] h_tgt;
    logic [LBA_W-1:0] h_lba;
    longint e_tgt;
    longint e_lba;
    longint e_sub;
    longint e_op;
    a = longint'(sector) * 512;
    rem = bytes;
    slog = $clog2(stripe);
    first = 1'b1;
    stall = 1'b0;
    iter = 0;
    e_op = (kind >= 2) ? 8'h70 : ((kind == 1) ? 8'h80 : 8'hC0);
    @(negedge clk);
    chk(req_ready, 1, "R11 ready when idle");
    req_sector = SECT_W'(sector);
    req_bytes = LEN_W'(bytes);
    req_kind = 2'(kind);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (bytes == 0) begin
      chk(done, 1, "R9 done after empty request");
      chk(cmd_valid, 0, "R9 empty request issues nothing");
      @(negedge clk);
      chk(done, 0, "R9 done is one cycle");
      return;
    end
    chk(req_ready, 0, "R11 busy after accept");
    while (rem > 0 && iter < 400) begin
      iter++;
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      rdy = lf[0] | lf[2];
      if (stall) begin
        chk(cmd_valid, 1, "R8 valid held");
        chk({cmd_opcode, cmd_subpage, 4'(cmd_target), 12'd0, cmd_lblock},
            {h_op, h_sub, 4'(h_tgt), 12'd0, h_lba}, "R8 fields held");
      end
      cmd_ready = rdy;
      if (cmd_valid && rdy) begin
        if (kind >= 2) begin
          off = 0;
          len = (rem < 4096) ? rem : 4096;
          e_sub = 0;
        end else begin
          off = int'(a % 4096);
          len = (rem < 4096 - off) ? rem : 4096 - off;
          e_sub = (((len / 512) % 8) << 4) | (off / 512);
        end
        e_tgt = (a >> slog) & ((longint'(1) << tl) - 1);
        e_lba = ((((a >> tl) & ~longint'(stripe - 1)) | (a & longint'(stripe - 1))) >> 12)
                & ((longint'(1) << LBA_W) - 1);
        chk(cmd_opcode, e_op, "R7 opcode");
        chk(cmd_target, e_tgt, "R2 target");
        chk(cmd_lblock, e_lba, first ? "R1 R3 first local block" : "R3 local block");
        chk(cmd_subpage, e_sub, (kind >= 2) ? "R6 discard subpage" : "R4 R5 subpage");
        a = a + ((kind >= 2) ? 4096 : len);
        rem = rem - len;
        first = 1'b0;
        stall = 1'b0;
      end else if (cmd_valid) begin
        stall = 1'b1;
        h_op = cmd_opcode;
        h_sub = cmd_subpage;
        h_tgt = cmd_target;
        h_lba = cmd_lblock;
      end else begin
        stall = 1'b0;
      end
      @(negedge clk);
    end
    cmd_ready = 1'b0;
    chk(done, 1, "R9 done after last chunk");
    chk(cmd_valid, 0, "R9 no extra chunk");
    @(negedge clk);
    chk(done, 0, "R9 done is one cycle");
    chk(req_ready, 1, "R11 ready after done");
  endtask

  initial begin
    int stripes[3];
    int tls[3];
    int secs[8];
    int lens[8];
    stripes = '{4096, 8192, 32768};
    tls = '{0, 1, 3};
    secs = '{0, 1, 7, 8, 9, 15, 100, 1000};
    lens = '{0, 1, 7, 8, 9, 16, 17, 33};

    @(negedge clk);
    chk(cfg_err, 1, "R12 cfg_err in reset");
    chk(req_ready, 0, "R12 req_ready in reset");
    chk(cmd_valid, 0, "R12 cmd_valid in reset");
    chk(done, 0, "R12 done in reset");
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(cfg_err, 0, "R10 valid stripe accepted");

    for (int si = 0; si < 3; si++) begin
      for (int ti = 0; ti < 3; ti++) begin
        set_cfg(stripes[si], tls[ti]);
        for (int k = 0; k < 3; k++) begin
          for (int s = 0; s < 8; s++) begin
            for (int l = 0; l < 8; l++) begin
              run_req(secs[s], lens[l] * 512, k, stripes[si], tls[ti]);
            end
          end
        end
      end
    end

    // R10: bad stripe sizes block and ignore requests
    set_cfg(12288, 1);
    chk(cfg_err, 1, "R10 non power of two rejected");
    chk(req_ready, 0, "R10 intake blocked");
    req_bytes = 20'd4096;
    req_kind = 2'd1;
    req_valid = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(cmd_valid, 0, "R10 request ignored");
      chk(done, 0, "R10 no done on ignored request");
    end
    req_valid = 1'b0;
    set_cfg(0, 1);
    chk(cfg_err, 1, "R10 zero stripe rejected");
    set_cfg(8192, 2);
    chk(cfg_err, 0, "R10 recovered");
    run_req(5, 9000 - (9000 % 512), 0, 8192, 2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule